// File: doc/BRIEF.md
# Per-Pin Interrupt Sense Unit

This unit watches a bank of already-synchronized input pins and turns activity on them into interrupt requests. Every pin owns a control word whose four-bit sense code chooses between no detection, active-low level, active-high level, rising edge, falling edge and both edges. When a pin's chosen condition occurs, a flag for that pin is latched in a shared status word. A single request line stays high as long as at least one flag is pending.

Software reaches the unit over a minimal memory-mapped port with a write strobe, a byte address, write data and combinational read data. It programs a sense code per pin and reads the status word to find out which pins fired. It then acknowledges them by writing ones to those bit positions. A level condition that is still present after its flag is acknowledged latches the flag again on the following clock, so a held level keeps requesting service.

Top module: `pin_irq_sense`

## Requirements
- R1: Pin n's control word sits at byte offset 4·n (n = 0..NUM_PINS-1). The sense code lives in bits 19:16, and a write stores only those bits. A read returns the stored code in bits 19:16 with all other bits zero, even when the code is undefined. Writes to an address whose low two bits are not zero change no control word.
- R2: With code 0x9, a pin's flag sets at a clock edge where the pin is 1 and was 0 at the previous edge.
- R3: With code 0xA, a pin's flag sets at a clock edge where the pin is 0 and was 1 at the previous edge.
- R4: With code 0xB, a pin's flag sets at a clock edge where the pin differs from its value at the previous edge.
- R5: With code 0x8 the flag sets at every clock edge where the pin is 0. With code 0xC it sets at every edge where the pin is 1. A flag cleared while the level persists is set again at the next edge.
- R6: Code 0x0 and every code other than 0x8 to 0xC never set a flag. Writing zero to a control word stops detection for that pin.
- R7: The status word is at offset 0xA0, with bit n the flag of pin n. Writing it clears each flag whose data bit is 1 and leaves the flags under 0 bits unchanged. Writing 0xFFFFFFFF clears all flags in one access.
- R8: When a pin's condition occurs in the same cycle as a write that clears its flag, the flag is set after that edge.
- R9: irqOut is 1 exactly while at least one status flag is set, with no added clock delay.
- R10: Reset (rstN low) clears all sense codes, all flags and the one-clock pin history, so irqOut is 0.
- R11: A set flag stays set until it is cleared through the status word, even if its pin's code is changed, including to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | NUM_PINS | Synchronized pin levels |
| busWrEn | input | 1 | Write strobe for one cycle |
| busAddr | input | ADDR_W | Byte address of the access |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Read data for busAddr, combinational |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The assertions take for granted that pinIn is already synchronized to clk and changes only between rising edges. They also assume that pins are held low while reset is applied, so that the cleared history matches the pins at release. The bench drives pins, addresses and data on the falling edge. It releases reset with every pin at zero and keeps the write strobe to single cycles, so every edge sees stable, fully defined inputs.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;
  localparam int IDX_W    = ADDR_W - 2;
  localparam int CODE_W   = 4;
  localparam int CODE_LSB = 16;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 8'hA0;

  localparam logic [CODE_W-1:0] SENSE_OFF  = 4'h0;
  localparam logic [CODE_W-1:0] SENSE_LOW  = 4'h8;
  localparam logic [CODE_W-1:0] SENSE_RISE = 4'h9;
  localparam logic [CODE_W-1:0] SENSE_FALL = 4'hA;
  localparam logic [CODE_W-1:0] SENSE_BOTH = 4'hB;
  localparam logic [CODE_W-1:0] SENSE_HIGH = 4'hC;

  typedef struct packed {
    logic             cfgWr;
    logic             clrWr;
    logic             cfgSel;
    logic             statSel;
    logic [IDX_W-1:0] idx;
  } strobe_t;

  function automatic logic senseHit(input logic [CODE_W-1:0] code,
                                    input logic cur, input logic prev);
    case (code)
      SENSE_LOW:  return ~cur;
      SENSE_HIGH: return cur;
      SENSE_RISE: return cur & ~prev;
      SENSE_FALL: return ~cur & prev;
      SENSE_BOTH: return cur ^ prev;
      default:    return 1'b0;
    endcase
  endfunction

  function automatic logic senseActive(input logic [CODE_W-1:0] code);
    return (code >= SENSE_LOW) && (code <= SENSE_HIGH);
  endfunction
endpackage

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strb
);
  logic [IDX_W-1:0] wordIdx;
  logic             aligned;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);

  always_comb begin
    strb         = '0;
    strb.idx     = wordIdx;
    strb.cfgSel  = aligned && (int'(wordIdx) < NUM_PINS);
    strb.statSel = (busAddr == STAT_ADDR);
    strb.cfgWr   = busWrEn && strb.cfgSel;
    strb.clrWr   = busWrEn && strb.statSel;
  end
endmodule

// File: rtl/pin_irq_datapath.sv
module pin_irq_datapath
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_PINS-1:0]        pinIn,
  input  logic [DATA_W-1:0]          busWrData,
  input  strobe_t                    strb,
  output logic [DATA_W-1:0]          busRdData,
  output logic                       irqOut,
  output logic [NUM_PINS-1:0]        statusQ,
  output logic [NUM_PINS-1:0]        prevQ,
  output logic [CODE_W*NUM_PINS-1:0] cfgFlat
);
  logic [NUM_PINS-1:0] hitVec;
  logic [NUM_PINS-1:0] clrVec;

  assign clrVec = strb.clrWr ? busWrData[NUM_PINS-1:0] : '0;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [CODE_W-1:0] codeQ;
    logic              selHere;

    assign selHere = (strb.idx == IDX_W'(p));

    always_ff @(posedge clk) begin
      if (!rstN)
        codeQ <= SENSE_OFF;
      else if (strb.cfgWr && selHere)
        codeQ <= busWrData[CODE_LSB +: CODE_W];
    end

    assign hitVec[p] = senseHit(codeQ, pinIn[p], prevQ[p]);
    assign cfgFlat[CODE_W*p +: CODE_W] = codeQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevQ   <= '0;
      statusQ <= '0;
    end else begin
      prevQ   <= pinIn;
      statusQ <= (statusQ & ~clrVec) | hitVec;
    end
  end

  assign irqOut = |statusQ;

  always_comb begin
    busRdData = '0;
    if (strb.statSel) begin
      busRdData[NUM_PINS-1:0] = statusQ;
    end else if (strb.cfgSel) begin
      for (int p = 0; p < NUM_PINS; p++)
        if (strb.idx == IDX_W'(p))
          busRdData[CODE_LSB +: CODE_W] = cfgFlat[CODE_W*p +: CODE_W];
    end
  end
endmodule

// File: rtl/pin_irq_sense.sv
module pin_irq_sense
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWrData,
  output logic [DATA_W-1:0]   busRdData,
  output logic                irqOut
);
  strobe_t                    strb;
  logic [NUM_PINS-1:0]        statusQ;
  logic [NUM_PINS-1:0]        prevQ;
  logic [CODE_W*NUM_PINS-1:0] cfgFlat;

  pin_irq_ctrl #(.NUM_PINS(NUM_PINS)) i_ctrl (
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .strb    (strb)
  );

  pin_irq_datapath #(.NUM_PINS(NUM_PINS)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .pinIn     (pinIn),
    .busWrData (busWrData),
    .strb      (strb),
    .busRdData (busRdData),
    .irqOut    (irqOut),
    .statusQ   (statusQ),
    .prevQ     (prevQ),
    .cfgFlat   (cfgFlat)
  );
endmodule

// File: rtl/pin_irq_checker.sv
module pin_irq_checker
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [NUM_PINS-1:0]        pinIn,
  input logic                       busWrEn,
  input logic [ADDR_W-1:0]          busAddr,
  input logic [DATA_W-1:0]          busRdData,
  input logic                       irqOut,
  input logic [NUM_PINS-1:0]        statusQ,
  input logic [NUM_PINS-1:0]        prevQ,
  input logic [CODE_W*NUM_PINS-1:0] cfgFlat
);
  // R9: status read and request line agree
  assert_irq_pending_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == STAT_ADDR && busRdData != '0) |-> irqOut);
  assert_irq_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == STAT_ADDR && busRdData == '0) |-> !irqOut);

  // R11: without a status write no flag drops
  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busAddr == STAT_ADDR) |=>
      ((statusQ & $past(statusQ)) == $past(statusQ)));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    // R6: a newly set flag needs an active code in the cycle before
    assert_code_active_R6: assert property (@(posedge clk) disable iff (!rstN)
      $rose(statusQ[i]) |-> senseActive($past(cfgFlat[CODE_W*i +: CODE_W])));
    // R2: rising-edge flag implies a 0 to 1 step on the pin
    assert_rise_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(statusQ[i]) && $past(cfgFlat[CODE_W*i +: CODE_W]) == SENSE_RISE)
        |-> ($past(pinIn[i]) && !$past(prevQ[i])));
    // R5 and R8: a held high level always leaves the flag set
    assert_level_high_R5: assert property (@(posedge clk) disable iff (!rstN)
      (cfgFlat[CODE_W*i +: CODE_W] == SENSE_HIGH && pinIn[i]) |=> statusQ[i]);
  end
endmodule

bind pin_irq_sense pin_irq_checker #(.NUM_PINS(NUM_PINS)) i_checker (
  .clk       (clk),
  .rstN      (rstN),
  .pinIn     (pinIn),
  .busWrEn   (busWrEn),
  .busAddr   (busAddr),
  .busRdData (busRdData),
  .irqOut    (irqOut),
  .statusQ   (statusQ),
  .prevQ     (prevQ),
  .cfgFlat   (cfgFlat)
);

// File: tb/test_pin_irq_sense.sv
`timescale 1ns/1ps
module test_pin_irq_sense;
  localparam int N = 32;
  localparam logic [7:0] STAT = 8'hA0;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] pinIn = '0;
  logic         busWrEn = 1'b0;
  logic [7:0]   busAddr = '0;
  logic [31:0]  busWrData = '0;
  logic [31:0]  busRdData;
  logic         irqOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [3:0]   cfgM [N];
  logic [N-1:0] statM = '0;
  logic [N-1:0] prevM = '0;

  always #2.5 clk = ~clk;

  pin_irq_sense #(.NUM_PINS(N)) i_pin_irq_sense (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .irqOut(irqOut)
  );

  function automatic logic hitOf(input logic [3:0] c, input logic cur, input logic prv);
    case (c)
      4'h8: return !cur;
      4'hC: return cur;
      4'h9: return cur && !prv;
      4'hA: return !cur && prv;
      4'hB: return cur != prv;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic [N-1:0] pins, input logic wr,
                      input logic [7:0] addr, input logic [31:0] data);
    logic [N-1:0] hits;
    @(negedge clk);
    pinIn = pins; busWrEn = wr; busAddr = addr; busWrData = data;
    for (int i = 0; i < N; i++) hits[i] = hitOf(cfgM[i], pins[i], prevM[i]);
    if (wr && addr == STAT) statM = statM & ~data;
    statM = statM | hits;
    if (wr && addr[1:0] == 2'b00 && addr[7:2] < N) cfgM[addr[7:2]] = data[19:16];
    prevM = pins;
    @(posedge clk);
    #0.5;
    busWrEn = 1'b0;
    check("R9 irqOut", {31'd0, irqOut}, {31'd0, |statM});
    busAddr = STAT;
    #0.5;
    check(tag, busRdData, statM);
  endtask

  task automatic rdChk(input string tag, input logic [7:0] addr);
    logic [31:0] exp;
    exp = '0;
    if (addr == STAT) exp = statM;
    else if (addr[1:0] == 2'b00 && addr[7:2] < N) exp[19:16] = cfgM[addr[7:2]];
    busAddr = addr;
    #0.3;
    check(tag, busRdData, exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] codes [8];
    codes = '{4'h0, 4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'h3, 4'hF};
    for (int i = 0; i < N; i++) cfgM[i] = 4'h0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #0.5;
    // R10: reset state
    check("R10 irq", {31'd0, irqOut}, 32'd0);
    rdChk("R10 status", STAT);
    rdChk("R10 cfg0", 8'h00);
    rdChk("R10 cfg31", 8'h7C);

    // R1: field-only read back, unaligned write ignored
    step("R1", '0, 1'b1, 8'h0C, 32'hFFFF_FFFF);
    rdChk("R1 readback", 8'h0C);
    step("R1", '0, 1'b1, 8'h0D, 32'h0009_0000);
    rdChk("R1 unaligned", 8'h0C);
    // R6: undefined code 0xF sets nothing
    step("R6 undefined", 32'h8, 1'b0, 8'h0, 0);
    step("R6 undefined", 32'h0, 1'b0, 8'h0, 0);

    // R2: rising on pin 0
    step("R2 cfg", '0, 1'b1, 8'h00, 32'h0009_0000);
    step("R2 rise", 32'h1, 1'b0, 8'h0, 0);
    step("R2 hold", 32'h1, 1'b1, STAT, 32'h1);
    step("R2 fall no flag", 32'h0, 1'b0, 8'h0, 0);
    // R8: rise with clear same cycle
    step("R8 event wins", 32'h1, 1'b1, STAT, 32'h1);
    // R11: disable keeps flag
    step("R11 cfg off", 32'h1, 1'b1, 8'h00, 32'h0);
    step("R11 sticky", 32'h0, 1'b0, 8'h0, 0);
    // R7: write zero leaves, write one clears
    step("R7 zero write", 32'h0, 1'b1, STAT, 32'h0);
    step("R7 clear", 32'h0, 1'b1, STAT, 32'h1);

    // R3 falling on pin 2, R4 both on pin 4
    step("R3 cfg", 32'h14, 1'b1, 8'h08, 32'h000A_0000);
    step("R4 cfg", 32'h14, 1'b1, 8'h10, 32'h000B_0000);
    step("R3 fall", 32'h10, 1'b0, 8'h0, 0);
    step("R4 fall", 32'h00, 1'b1, STAT, 32'h4);
    step("R4 rise", 32'h10, 1'b1, STAT, 32'h10);

    // R5: level high pin 5 re-sets after clear, level low pin 6
    step("R5 cfg high", 32'h30, 1'b1, 8'h14, 32'h000C_0000);
    step("R5 cfg low", 32'h70, 1'b1, 8'h18, 32'h0008_0000);
    step("R5 level", 32'h30, 1'b0, 8'h0, 0);
    step("R5 reassert", 32'h30, 1'b1, STAT, 32'h60);
    step("R5 low gone", 32'h70, 1'b1, STAT, 32'h40);
    // R7: all-ones clear
    step("R6 disable 5", 32'h10, 1'b1, 8'h14, 32'h0);
    step("R7 clear all", 32'h10, 1'b1, STAT, 32'hFFFF_FFFF);
    rdChk("R7 after all", STAT);

    // random mix
    for (int k = 0; k < 600; k++) begin
      logic [N-1:0] pins;
      int op;
      logic [31:0] d;
      pins = $urandom;
      op = $urandom_range(0, 3);
      d = $urandom;
      case (op)
        1: begin
          d[19:16] = codes[$urandom_range(0, 7)];
          step("R1 rand cfg", pins, 1'b1, 8'($urandom_range(0, N-1) * 4), d);
        end
        2: step("R7 rand clr", pins, 1'b1, STAT, d);
        3: step("R7 rand all", pins, 1'b1, STAT, 32'hFFFF_FFFF);
        default: step("R5 rand", pins, 1'b0, 8'h0, 0);
      endcase
      rdChk("R1 rand read", 8'($urandom_range(0, N-1) * 4));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule